// File: doc/BRIEF.md
# Sequence-Unlocked Sector Write Guard

This block sits beside a word-addressed memory array and watches every completed bus access. Each access is presented for one clock cycle as an address, a read/write flag, the low data byte and a flag that says whether the access opened a new chip-enable cycle. The block holds an 8-bit protection setting with one bit per 16K-word sector. In the same cycle as each access it reports whether the addressed sector is write-protected.

The setting can only be changed through a fixed chain of ten accesses. Six reads at fixed addresses come first, then three writes at fixed addresses, then one final read at address zero. The first write carries the new setting and the second must carry its exact bitwise complement. The third write's data is ignored. Any access that does not fit the chain silently drops the attempt. The writes that do belong to the chain are flagged so the array controller can keep them out of storage. Reads within the chain are ordinary reads.

The setting is held in a plain register with an all-unprotected reset value. The bus timing itself is handled elsewhere.

Top module: `sector_guard`

## Requirements
- R1: After synchronous reset every sector is unprotected: `wr_inhibit` is 0 for every address.
- R2: The full chain loads `acc_data[7:0]` of the first chain write into the setting. The chain is: reads at 12555h, 1DAAAh, 01333h, 0ECCCh, 000FFh and 1FF00h, in that order; then writes at 1DAAAh, 0ECCCh and 0FF00h; then a read at 00000h. Bit n of the setting protects sector n, which is the set of addresses with `acc_addr[16:14]` equal to n.
- R3: `wr_inhibit` is combinational. It is the setting bit selected by `acc_addr[16:14]`, where 1 means protected. It does not depend on `acc_valid`.
- R4: The setting does not change before the final read at 00000h is accepted. The new value shows from the cycle after that read.
- R5: If the second chain write does not carry the exact bitwise complement of the first write's byte, the attempt is dropped and the setting stays unchanged.
- R6: Any access that does not match the expected address and direction drops the attempt without changing the setting. This includes a seventh read in place of the first write. The remaining chain accesses presented after such a break do not complete it.
- R7: `seq_write` is 1 in the same cycle as an accepted write that hits the expected address of one of the three chain write steps, whatever its data. It is 0 for reads and for all other writes.
- R8: The first chain access (read at 12555h) is accepted only if `acc_fresh` is 1, or if the previous valid access was at 00000h.
- R9: An access that breaks an attempt but is itself an acceptable first step starts a new attempt as step one.
- R10: The data of the third chain write has no effect on the loaded setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle strobe for a completed access |
| acc_addr | input | 17 | Word address of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_data | input | 8 | Low data byte of the access |
| acc_fresh | input | 1 | Access began with a new chip-enable cycle |
| prot_q | output | 8 | Current protection setting, one bit per sector |
| wr_inhibit | output | 1 | Addressed sector is write-protected |
| seq_write | output | 1 | This write belongs to the unlock chain; do not store it |

## Verification
An access that breaks an attempt can also be an acceptable first step. In that cycle the abort and the start of a new attempt happen together. The bench provokes this by breaking a partial chain with a fresh read at 12555h and then continuing straight into steps two to ten. It judges the result by whether the new byte loads. The other overlap is the commit on the final read against the combinational inhibit. Just before that read, a sector sweep must still show the old setting. A sweep after the read must show the new one.

// File: rtl/sg_pkg.sv
// Package: shared constants, step type and the unlock chain table.
// Assumes a 17-bit word address; the chain addresses are fixed at that width.
package sg_pkg;
    localparam int ADDR_W   = 17;
    localparam int SEQ_LEN  = 10;
    localparam int STEP_W   = $clog2(SEQ_LEN);
    localparam int STEP_BYTE = 6;   // write carrying the new setting
    localparam int STEP_CMP  = 7;   // write carrying the complement
    localparam int STEP_LAST = SEQ_LEN - 1;

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t START_ADDR = 17'h12555;
    localparam addr_t ZERO_ADDR  = 17'h00000;

    // Expected address for each chain step.
    function automatic addr_t seq_addr(input step_t s);
        case (s)
            4'd0:    return 17'h12555;
            4'd1:    return 17'h1DAAA;
            4'd2:    return 17'h01333;
            4'd3:    return 17'h0ECCC;
            4'd4:    return 17'h000FF;
            4'd5:    return 17'h1FF00;
            4'd6:    return 17'h1DAAA;
            4'd7:    return 17'h0ECCC;
            4'd8:    return 17'h0FF00;
            default: return 17'h00000;
        endcase
    endfunction

    // Expected direction for each chain step (1 = write).
    function automatic logic seq_is_wr(input step_t s);
        return (s >= step_t'(STEP_BYTE)) && (s <= step_t'(STEP_BYTE + 2));
    endfunction
endpackage

// File: rtl/sg_tracker.sv
// Chain tracker: follows the ten-step unlock chain, holds the candidate
// byte and raises a one-cycle commit on the accepted final read.
// Assumes each access is presented for exactly one cycle with acc_valid.
module sg_tracker
    import sg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  addr_t             acc_addr,
    input  logic              acc_write,
    input  logic [BYTE_W-1:0] acc_data,
    input  logic              acc_fresh,
    output logic              seq_write,
    output logic              commit,
    output logic [BYTE_W-1:0] pend_q
);
    step_t step_q;
    logic  prev_zero_q;
    addr_t exp_addr;
    logic  exp_wr;
    logic  start_ok, addr_hit, data_ok, gate_ok, advance, restart;

    // Decode the expectation for the current step and classify the access.
    always_comb begin
        exp_addr  = seq_addr(step_q);
        exp_wr    = seq_is_wr(step_q);
        start_ok  = acc_fresh || prev_zero_q;
        addr_hit  = (acc_addr == exp_addr) && (acc_write == exp_wr);
        data_ok   = (step_q != step_t'(STEP_CMP)) || (acc_data == ~pend_q);
        gate_ok   = (step_q != '0) || start_ok;
        advance   = acc_valid && addr_hit && data_ok && gate_ok;
        restart   = acc_valid && !acc_write && (acc_addr == START_ADDR) && start_ok;
        commit    = advance && (step_q == step_t'(STEP_LAST));
        seq_write = acc_valid && acc_write && exp_wr && (acc_addr == exp_addr);
    end

    // Step register: advance on a match, else drop or restart at step one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (acc_valid) begin
            if (advance)
                step_q <= commit ? '0 : step_q + step_t'(1);
            else
                step_q <= restart ? step_t'(1) : '0;
        end
    end

    // Candidate byte captured from the first chain write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (advance && (step_q == step_t'(STEP_BYTE)))
            pend_q <= acc_data;
    end

    // Remember whether the last valid access was at address zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_zero_q <= 1'b0;
        else if (acc_valid)
            prev_zero_q <= (acc_addr == ZERO_ADDR);
    end
endmodule

// File: rtl/sg_prot_reg.sv
// Protection register: stands in for the nonvolatile setting; loads the
// candidate byte on commit. Reset value is all sectors unprotected.
module sg_prot_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BYTE_W-1:0] pend,
    output logic [BYTE_W-1:0] prot_q
);
    // Hold the setting; replace it only on a completed chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_q <= '0;
        else if (commit)
            prot_q <= pend;
    end
endmodule

// File: rtl/sg_sector_dec.sv
// Sector decoder: selects the protection bit of the sector picked by the
// top address bits. Purely combinational.
module sg_sector_dec #(
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [SECT_W-1:0] sect,
    input  logic [NSECT-1:0]  prot,
    output logic              inhibit
);
    logic [NSECT-1:0] hit;

    // One compare per sector, gated by that sector's bit.
    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign hit[g] = (sect == SECT_W'(g)) && prot[g];
    end

    // Any gated hit means the addressed sector is protected.
    assign inhibit = |hit;
endmodule

// File: rtl/sector_guard.sv
// Top: sector write guard unlocked by a fixed access chain.
// Assumes one-cycle access strobes; the sector index is the top SECT_W
// address bits, and the data byte width equals the sector count.
module sector_guard
    import sg_pkg::*;
#(
    parameter int SECT_W = 3,
    localparam int BYTE_W = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [16:0]       acc_addr,
    input  logic              acc_write,
    input  logic [BYTE_W-1:0] acc_data,
    input  logic              acc_fresh,
    output logic [BYTE_W-1:0] prot_q,
    output logic              wr_inhibit,
    output logic              seq_write
);
    logic              commit;
    logic [BYTE_W-1:0] pend;

    sg_tracker #(.BYTE_W(BYTE_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_data  (acc_data),
        .acc_fresh (acc_fresh),
        .seq_write (seq_write),
        .commit    (commit),
        .pend_q    (pend)
    );

    sg_prot_reg #(.BYTE_W(BYTE_W)) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .pend   (pend),
        .prot_q (prot_q)
    );

    sg_sector_dec #(.SECT_W(SECT_W)) u_dec (
        .sect    (acc_addr[ADDR_W-1 -: SECT_W]),
        .prot    (prot_q),
        .inhibit (wr_inhibit)
    );
endmodule

// File: rtl/sector_guard_chk.sv
// Checker: port-level properties of sector_guard, attached by bind.
module sector_guard_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [16:0]       acc_addr,
    input logic              acc_write,
    input logic [BYTE_W-1:0] prot_q,
    input logic              wr_inhibit,
    input logic              seq_write
);
    // R1: reset leaves every sector open.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> prot_q == '0);

    // R4: the setting moves only after an accepted read at address zero.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write && acc_addr == 17'h0) |=> $stable(prot_q));

    // R3: an all-open setting never inhibits, an all-closed one always does.
    p_inhibit_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q == '0) |-> !wr_inhibit);
    p_inhibit_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&prot_q) |-> wr_inhibit);

    // R7: the chain flag marks only valid writes at chain write addresses.
    p_seqwr_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_write |-> (acc_valid && acc_write));
    p_seqwr_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_write |-> (acc_addr == 17'h1DAAA || acc_addr == 17'h0ECCC ||
                       acc_addr == 17'h0FF00));
endmodule

bind sector_guard sector_guard_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .prot_q     (prot_q),
    .wr_inhibit (wr_inhibit),
    .seq_write  (seq_write)
);

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [16:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_data = '0;
    logic        acc_fresh = 1'b0;
    logic [7:0]  prot_q;
    logic        wr_inhibit;
    logic        seq_write;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_prot = '0;
    logic [16:0] chain [10] = '{17'h12555, 17'h1DAAA, 17'h01333, 17'h0ECCC,
                                17'h000FF, 17'h1FF00, 17'h1DAAA, 17'h0ECCC,
                                17'h0FF00, 17'h00000};

    sector_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_data(acc_data), .acc_fresh(acc_fresh),
        .prot_q(prot_q), .wr_inhibit(wr_inhibit), .seq_write(seq_write)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Present one access at posedge+1, check the chain flag, consume it.
    task automatic access(input logic [16:0] a, input logic w, input logic [7:0] d,
                          input logic f, input logic exp_sw);
        acc_addr = a; acc_write = w; acc_data = d; acc_fresh = f; acc_valid = 1'b1;
        #1;
        checks++;
        if (seq_write !== exp_sw) begin
            errors++;
            $display("FAIL R7: seq_write at %h w=%0b got %0b exp %0b", a, w, seq_write, exp_sw);
        end
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    // Walk all sectors and compare the inhibit with the expected setting (R2, R3).
    task automatic sweep(input logic [7:0] e, input string tag);
        for (int s = 0; s < 8; s++) begin
            acc_addr = {s[2:0], 14'h1A5};
            #1;
            checks++;
            if (wr_inhibit !== e[s]) begin
                errors++;
                $display("FAIL %s: sector %0d inhibit got %0b exp %0b", tag, s, wr_inhibit, e[s]);
            end
        end
        @(posedge clk); #1;
    endtask

    // Drive the chain; brk >= 0 inserts a breaking access before that step.
    task automatic run_seq(input logic [7:0] b, input logic [7:0] cmp, input logic [7:0] third,
                           input logic f0, input logic start_ok, input int brk,
                           input logic seventh_rd);
        logic on;
        on = start_ok;
        for (int i = 0; i < 10; i++) begin
            logic wr;
            logic [7:0] d;
            wr = (i >= 6) && (i <= 8);
            d = (i == 6) ? b : (i == 7) ? cmp : (i == 8) ? third : 8'h00;
            if (i == brk) begin
                if (seventh_rd) access(chain[6], 1'b0, 8'h00, 1'b0, 1'b0); // R6 seventh read
                else            access(17'h00001, wr, 8'h33, 1'b0, 1'b0);  // R6 wrong address
                on = 1'b0;
            end
            if (i == 9) sweep(exp_prot, "R4");
            access(chain[i], wr, d, (i == 0) ? f0 : 1'b0, on && wr);
            if (i == 7 && cmp != ~b) on = 1'b0;
        end
        if (on) exp_prot = b;
        sweep(exp_prot, on ? "R2" : "R5/R6");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        sweep(8'h00, "R1");

        // R2 R3 R10: every byte value, third-write data varied.
        for (int b = 0; b < 256; b++)
            run_seq(8'(b), ~8'(b), 8'(b) ^ 8'h5A, 1'b1, 1'b1, -1, 1'b0);

        // Known value for the abort tests.
        run_seq(8'hA5, 8'h5A, 8'hFF, 1'b1, 1'b1, -1, 1'b0);

        // R5: wrong complement, each single-bit error.
        for (int k = 0; k < 8; k++)
            run_seq(8'h3C, ~8'h3C ^ (8'h1 << k), 8'h00, 1'b1, 1'b1, -1, 1'b0);

        // R6: break at every step after the first.
        for (int k = 1; k < 10; k++)
            run_seq(8'h0F, 8'hF0, 8'h00, 1'b1, 1'b1, k, 1'b0);

        // R6: seventh read in place of the first write.
        run_seq(8'h0F, 8'hF0, 8'h00, 1'b1, 1'b1, 6, 1'b1);

        // R8: not fresh and previous access not at zero -> rejected.
        access(17'h00005, 1'b0, 8'h00, 1'b1, 1'b0);
        run_seq(8'h11, 8'hEE, 8'h00, 1'b0, 1'b0, -1, 1'b0);
        // R8: not fresh but preceded by address zero -> accepted.
        access(17'h00000, 1'b0, 8'h00, 1'b0, 1'b0);
        run_seq(8'h22, 8'hDD, 8'h00, 1'b0, 1'b1, -1, 1'b0);

        // R9: partial attempt broken by a fresh first step that restarts it.
        for (int i = 0; i < 3; i++) access(chain[i], 1'b0, 8'h00, i == 0, 1'b0);
        run_seq(8'hC3, 8'h3C, 8'h00, 1'b1, 1'b1, -1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule